// File: doc/BRIEF.md
# Interrupt Priority Controller

This block collects a parameterised number of external interrupt request lines (up to 256) and presents the most urgent one to a processor core. Each line has an enable bit, a pending bit, an active bit and an 8-bit priority byte. Of that byte only the upper `PRIO_BITS` bits are stored. A rising edge on a request input marks the line pending. Among the lines that are both enabled and pending, the combinational selector picks the one with the numerically lowest priority. On a priority tie, the lower line number wins. The selector drives the line number, its priority and a valid flag.

Software reaches the state through a 32-bit word-addressed bus. Writes take effect at the next clock edge, and reads are combinational. Enable and pending are each reached through a pair of alias windows. A 1 written to a set alias sets the matching bit, a 1 written to a clear alias clears it, and a 0 bit changes nothing. Both aliases read back the current state. The core drives `ack` to take the selected line: that line moves from pending to active. Later an end-of-service strobe names a line whose active bit is then cleared. Preemption, grouping of priorities and the sequencing of exception entry are left to the core.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After synchronous reset every enable, pending, active and priority bit is zero, `sel_valid` is low and every register window reads zero.
- R2: Enable bits are set by writing 1s to word address 0x00+w (byte offset 0x000) and cleared by writing 1s to word address 0x20+w (byte offset 0x080). Line n sits in word w = n/32 at bit n%32. A 0 bit leaves the state as it is, and both windows read the enable state.
- R3: Pending bits use the same scheme: set through word address 0x40+w (byte offset 0x100) and cleared through word address 0x60+w (byte offset 0x180). Both windows read the pending state.
- R4: A 0-to-1 transition on `irq_req[n]` sets pending for line n whether or not the line is enabled. A request held high does not set pending again after software clears it.
- R5: Priority for line n is the byte at bits 8*(n%4)+7..8*(n%4) of word address 0xC0+n/4 (byte offset 0x300). Only the upper `PRIO_BITS` bits of each byte are kept. The lower bits read zero and ignore writes.
- R6: `sel_valid` is high exactly when some line is enabled and pending. It follows the stored state in the same cycle. `sel_id`/`sel_prio` then name the eligible line with the numerically lowest priority, together with that priority.
- R7: When eligible lines share the lowest priority, the lowest line number is selected.
- R8: `ack` while `sel_valid` is high clears pending and sets active for the selected line at the next edge. `ack` while `sel_valid` is low changes nothing.
- R9: The active bits read at word address 0x80+w (byte offset 0x200) and ignore bus writes. An `eos_strobe` clears the active bit of line `eos_id` at the next edge.
- R10: Bits and bytes for line numbers at or above `NUM_LINES` read zero and ignore writes. The window at word address 0xA0..0xBF reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_waddr | input | 8 | Word address (byte offset / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_waddr`, combinational |
| irq_req | input | NUM_LINES | Interrupt request lines, rising edge sensitive |
| ack | input | 1 | Core takes the currently selected line |
| eos_strobe | input | 1 | End of service for line `eos_id` |
| eos_id | input | $clog2(NUM_LINES) | Line whose service has finished |
| sel_valid | output | 1 | An enabled, pending line exists |
| sel_id | output | $clog2(NUM_LINES) | Number of the selected line |
| sel_prio | output | 8 | Priority byte of the selected line |

## Verification
The bench builds the block with `NUM_LINES = 40` and `PRIO_BITS = 3`. With 40 lines the second word of every bit window is only partly populated, so writes to bits 8..31 of that word must read back as zero. Three priority bits leave five dead bits in each byte, and a write of all ones shows that masking plainly. Ties at priority zero across neighbouring lines exercise the line-number order, and an acknowledge given while nothing is selected must leave the state untouched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Register window selected by bus_waddr[7:5]
    typedef enum logic [2:0] {
        WIN_EN_SET  = 3'd0,
        WIN_EN_CLR  = 3'd1,
        WIN_PD_SET  = 3'd2,
        WIN_PD_CLR  = 3'd3,
        WIN_ACTIVE  = 3'd4,
        WIN_GAP     = 3'd5,
        WIN_PRIO    = 3'd6
    } win_e;

    // One-hot-ish write strobes for the bit windows
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pd_set;
        logic pd_clr;
        logic prio;
    } wr_sel_t;

    function automatic win_e decode_win(input logic [7:0] waddr);
        case (waddr[7:5])
            3'd0:    return WIN_EN_SET;
            3'd1:    return WIN_EN_CLR;
            3'd2:    return WIN_PD_SET;
            3'd3:    return WIN_PD_CLR;
            3'd4:    return WIN_ACTIVE;
            3'd5:    return WIN_GAP;
            default: return WIN_PRIO;
        endcase
    endfunction

    // Mask of the implemented upper priority bits
    function automatic logic [7:0] prio_keep(input int bits);
        logic [7:0] m;
        m = 8'hFF << (8 - bits);
        return m;
    endfunction

endpackage

// File: rtl/irqc_bits.sv
module irqc_bits #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic [NUM_LINES-1:0] en_set,
    input  logic [NUM_LINES-1:0] en_clr,
    input  logic [NUM_LINES-1:0] pd_set,
    input  logic [NUM_LINES-1:0] pd_clr,
    input  logic [NUM_LINES-1:0] take_mask,
    input  logic [NUM_LINES-1:0] done_mask,
    output logic [NUM_LINES-1:0] en_q,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] act_q
);

    logic [NUM_LINES-1:0] req_q;
    logic [NUM_LINES-1:0] req_rise;

    assign req_rise = irq_req & ~req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            req_q  <= '0;
        end else begin
            req_q  <= irq_req;
            en_q   <= (en_q & ~en_clr) | en_set;
            // clears first, then sets and new edges
            pend_q <= (pend_q & ~pd_clr & ~take_mask) | pd_set | req_rise;
            act_q  <= (act_q & ~done_mask) | take_mask;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int NUM_LINES = 64,
    parameter int PRIO_BITS = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [5:0]             wr_word,
    input  logic [31:0]            wr_data,
    output logic [NUM_LINES*8-1:0] prio_flat
);

    localparam logic [7:0] KEEP = irqc_pkg::prio_keep(PRIO_BITS);

    logic [7:0] prio_q [NUM_LINES];

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam int WORD = l / 4;
        localparam int LANE = l % 4;

        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[l] <= '0;
            end else if (wr_en && (wr_word == 6'(WORD))) begin
                prio_q[l] <= wr_data[LANE*8 +: 8] & KEEP;
            end
        end

        assign prio_flat[l*8 +: 8] = prio_q[l];
    end

endmodule

// File: rtl/irqc_select.sv
module irqc_select #(
    parameter int NUM_LINES = 64,
    localparam int ID_W = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]   eligible,
    input  logic [NUM_LINES*8-1:0] prio_flat,
    output logic                   pick_valid,
    output logic [ID_W-1:0]        pick_id,
    output logic [7:0]             pick_prio
);

    // Ascending scan with strict compare: ties keep the lower line
    always_comb begin
        pick_valid = 1'b0;
        pick_id    = '0;
        pick_prio  = 8'hFF;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (eligible[l] && (!pick_valid || (prio_flat[l*8 +: 8] < pick_prio))) begin
                pick_valid = 1'b1;
                pick_id    = ID_W'(l);
                pick_prio  = prio_flat[l*8 +: 8];
            end
        end
        if (!pick_valid) begin
            pick_prio = 8'h00;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
    parameter int NUM_LINES = 64,
    parameter int PRIO_BITS = 3,
    localparam int ID_W = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [7:0]           bus_waddr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 ack,
    input  logic                 eos_strobe,
    input  logic [ID_W-1:0]      eos_id,
    output logic                 sel_valid,
    output logic [ID_W-1:0]      sel_id,
    output logic [7:0]           sel_prio
);

    import irqc_pkg::*;

    win_e                   win;
    wr_sel_t                wsel;
    logic [4:0]             bit_word;
    logic [5:0]             prio_word;
    logic [NUM_LINES-1:0]   wr_bits;
    logic [NUM_LINES-1:0]   en_set, en_clr, pd_set, pd_clr;
    logic [NUM_LINES-1:0]   take_mask, done_mask;
    logic [NUM_LINES-1:0]   en_q, pend_q, act_q;
    logic [NUM_LINES*8-1:0] prio_flat;
    logic [NUM_LINES-1:0]   rd_src;

    assign win       = decode_win(bus_waddr);
    assign bit_word  = bus_waddr[4:0];
    assign prio_word = bus_waddr[5:0];

    always_comb begin
        wsel        = '0;
        wsel.en_set = bus_wr && (win == WIN_EN_SET);
        wsel.en_clr = bus_wr && (win == WIN_EN_CLR);
        wsel.pd_set = bus_wr && (win == WIN_PD_SET);
        wsel.pd_clr = bus_wr && (win == WIN_PD_CLR);
        wsel.prio   = bus_wr && (win == WIN_PRIO);
    end

    // Per-line view of the written word
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_wbit
        assign wr_bits[l] = (bit_word == 5'(l / 32)) && bus_wdata[l % 32];
    end

    assign en_set = wsel.en_set ? wr_bits : '0;
    assign en_clr = wsel.en_clr ? wr_bits : '0;
    assign pd_set = wsel.pd_set ? wr_bits : '0;
    assign pd_clr = wsel.pd_clr ? wr_bits : '0;

    always_comb begin
        take_mask = '0;
        if (ack && sel_valid) begin
            take_mask[sel_id] = 1'b1;
        end
        done_mask = '0;
        if (eos_strobe && (int'(eos_id) < NUM_LINES)) begin
            done_mask[eos_id] = 1'b1;
        end
    end

    irqc_bits #(.NUM_LINES(NUM_LINES)) u_bits (
        .clk       (clk),
        .rst       (rst),
        .irq_req   (irq_req),
        .en_set    (en_set),
        .en_clr    (en_clr),
        .pd_set    (pd_set),
        .pd_clr    (pd_clr),
        .take_mask (take_mask),
        .done_mask (done_mask),
        .en_q      (en_q),
        .pend_q    (pend_q),
        .act_q     (act_q)
    );

    irqc_prio #(.NUM_LINES(NUM_LINES), .PRIO_BITS(PRIO_BITS)) u_prio (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wsel.prio),
        .wr_word   (prio_word),
        .wr_data   (bus_wdata),
        .prio_flat (prio_flat)
    );

    irqc_select #(.NUM_LINES(NUM_LINES)) u_sel (
        .eligible   (en_q & pend_q),
        .prio_flat  (prio_flat),
        .pick_valid (sel_valid),
        .pick_id    (sel_id),
        .pick_prio  (sel_prio)
    );

    // Read path
    always_comb begin
        case (win)
            WIN_EN_SET, WIN_EN_CLR: rd_src = en_q;
            WIN_PD_SET, WIN_PD_CLR: rd_src = pend_q;
            WIN_ACTIVE:             rd_src = act_q;
            default:                rd_src = '0;
        endcase
    end

    always_comb begin
        int ln;
        bus_rdata = '0;
        if (win == WIN_PRIO) begin
            for (int k = 0; k < 4; k++) begin
                ln = int'(prio_word) * 4 + k;
                if (ln < NUM_LINES) begin
                    bus_rdata[k*8 +: 8] = prio_flat[ln*8 +: 8];
                end
            end
        end else begin
            for (int b = 0; b < 32; b++) begin
                ln = int'(bit_word) * 32 + b;
                if (ln < NUM_LINES) begin
                    bus_rdata[b] = rd_src[ln];
                end
            end
        end
    end

endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_LINES = 64,
    parameter int PRIO_BITS = 3,
    localparam int ID_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 ack,
    input logic                 sel_valid,
    input logic [ID_W-1:0]      sel_id,
    input logic [7:0]           sel_prio,
    input logic [NUM_LINES-1:0] en_vec,
    input logic [NUM_LINES-1:0] pend_vec,
    input logic [NUM_LINES-1:0] act_vec,
    input logic                 eos_strobe,
    input logic [ID_W-1:0]      eos_id
);

    localparam logic [7:0] KEEP = irqc_pkg::prio_keep(PRIO_BITS);

    p_pick_eligible_r6: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (en_vec[sel_id] && pend_vec[sel_id]));

    p_idle_means_none_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> ((en_vec & pend_vec) == '0));

    p_prio_low_bits_zero_r5: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> ((sel_prio & ~KEEP) == 8'h00));

    p_take_sets_active_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && sel_valid) |=> act_vec[$past(sel_id)]);

    p_done_clears_active_r9: assert property (@(posedge clk) disable iff (rst)
        (eos_strobe && !(ack && sel_valid && (sel_id == eos_id))) |=> !act_vec[$past(eos_id)]);

endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
    .NUM_LINES (NUM_LINES),
    .PRIO_BITS (PRIO_BITS)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .sel_valid  (sel_valid),
    .sel_id     (sel_id),
    .sel_prio   (sel_prio),
    .en_vec     (en_q),
    .pend_vec   (pend_q),
    .act_vec    (act_q),
    .eos_strobe (eos_strobe),
    .eos_id     (eos_id)
);

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;

    localparam int N    = 40;
    localparam int PB   = 3;
    localparam int ID_W = $clog2(N);

    localparam logic [7:0] A_ENS = 8'h00;
    localparam logic [7:0] A_ENC = 8'h20;
    localparam logic [7:0] A_PDS = 8'h40;
    localparam logic [7:0] A_PDC = 8'h60;
    localparam logic [7:0] A_ACT = 8'h80;
    localparam logic [7:0] A_GAP = 8'hA0;
    localparam logic [7:0] A_PRI = 8'hC0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [7:0]      bus_waddr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [N-1:0]    irq_req = '0;
    logic            ack = 1'b0;
    logic            eos_strobe = 1'b0;
    logic [ID_W-1:0] eos_id = '0;
    logic            sel_valid;
    logic [ID_W-1:0] sel_id;
    logic [7:0]      sel_prio;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    irq_prio_ctrl #(.NUM_LINES(N), .PRIO_BITS(PB)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .bus_waddr  (bus_waddr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq_req    (irq_req),
        .ack        (ack),
        .eos_strobe (eos_strobe),
        .eos_id     (eos_id),
        .sel_valid  (sel_valid),
        .sel_id     (sel_id),
        .sel_prio   (sel_prio)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_waddr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_waddr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic sel_chk(input string tag, input logic v, input int id, input int pr);
        @(negedge clk);
        #1;
        chk({tag, " valid"}, 32'(sel_valid), 32'(v));
        if (v) begin
            chk({tag, " id"}, 32'(sel_id), 32'(id));
            chk({tag, " prio"}, 32'(sel_prio), 32'(pr));
        end
    endtask

    task automatic clear_all();
        wr(A_ENC,     32'hFFFF_FFFF);
        wr(A_ENC + 1, 32'hFFFF_FFFF);
        wr(A_PDC,     32'hFFFF_FFFF);
        wr(A_PDC + 1, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        sel_chk("R1 reset select", 1'b0, 0, 0);
        rd_chk("R1 reset enable", A_ENS, 32'h0);
        rd_chk("R1 reset pending", A_PDS, 32'h0);
        rd_chk("R1 reset active", A_ACT, 32'h0);
        rd_chk("R1 reset prio", A_PRI, 32'h0);
    endtask

    task automatic t_enable();
        wr(A_ENS, 32'h0000_0005);
        rd_chk("R2 set alias read", A_ENS, 32'h5);
        rd_chk("R2 clear alias read", A_ENC, 32'h5);
        wr(A_ENC, 32'h0000_0001);
        rd_chk("R2 clear one bit", A_ENS, 32'h4);
        wr(A_ENS, 32'h0);
        wr(A_ENC, 32'h0);
        rd_chk("R2 zero writes ignored", A_ENS, 32'h4);
        wr(A_ENS + 1, 32'h0000_0080);
        rd_chk("R2 line 39 word 1 bit 7", A_ENS + 1, 32'h80);
        wr(A_ENS + 1, 32'hFFFF_FFFF);
        rd_chk("R10 lines past end read zero", A_ENC + 1, 32'hFF);
        wr(A_PDS, 32'h0000_0300);
        rd_chk("R3 pending set alias", A_PDC, 32'h300);
        wr(A_PDC, 32'h0000_0100);
        rd_chk("R3 pending clear alias", A_PDS, 32'h200);
        clear_all();
    endtask

    task automatic t_prio();
        wr(A_PRI, 32'hFFFF_FFFF);
        rd_chk("R5 low bits dropped", A_PRI, 32'hE0E0_E0E0);
        wr(A_PRI + 1, 32'h1234_5678);
        rd_chk("R5 lanes masked", A_PRI + 1, 32'h0020_4060);
        wr(A_PRI + 10, 32'hFFFF_FFFF);
        rd_chk("R10 prio word past end", A_PRI + 10, 32'h0);
    endtask

    task automatic t_edge();
        @(negedge clk);
        irq_req[3] = 1'b1;
        rd_chk("R4 edge sets pending while disabled", A_PDS, 32'h8);
        sel_chk("R4 disabled line not selected", 1'b0, 0, 0);
        wr(A_PDC, 32'h8);
        @(negedge clk);
        @(negedge clk);
        rd_chk("R4 held level does not re-pend", A_PDS, 32'h0);
        @(negedge clk);
        irq_req[3] = 1'b0;
        @(negedge clk);
        irq_req[3] = 1'b1;
        rd_chk("R4 new edge pends again", A_PDS, 32'h8);
        irq_req[3] = 1'b0;
        clear_all();
    endtask

    task automatic t_select();
        // lines 4..7 prio: 0x60, 0x40, 0x20, 0x00
        wr(A_PDS, 32'h0000_0070);
        wr(A_ENS, 32'h0000_0070);
        sel_chk("R6 lowest value wins", 1'b1, 6, 8'h20);
        wr(A_PDS, 32'h0000_0080);
        sel_chk("R6 pending without enable ignored", 1'b1, 6, 8'h20);
        wr(A_ENS, 32'h0000_0080);
        sel_chk("R6 new most urgent line", 1'b1, 7, 8'h00);
        clear_all();
    endtask

    task automatic t_tie();
        wr(A_PDS, 32'h0000_0600);
        wr(A_ENS, 32'h0000_0600);
        sel_chk("R7 tie lower line wins", 1'b1, 9, 8'h00);
        wr(A_ENC, 32'h0000_0200);
        sel_chk("R7 next line after disable", 1'b1, 10, 8'h00);
    endtask

    task automatic t_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rd_chk("R8 active set", A_ACT, 32'h400);
        rd_chk("R8 pending cleared", A_PDS, 32'h200);
        sel_chk("R8 nothing left", 1'b0, 0, 0);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        rd_chk("R8 ack without valid ignored active", A_ACT, 32'h400);
        rd_chk("R8 ack without valid ignored pending", A_PDS, 32'h200);
    endtask

    task automatic t_eos();
        wr(A_ACT, 32'hFFFF_FFFF);
        rd_chk("R9 active read only", A_ACT, 32'h400);
        @(negedge clk);
        eos_id     = ID_W'(10);
        eos_strobe = 1'b1;
        @(negedge clk);
        eos_strobe = 1'b0;
        rd_chk("R9 end of service clears", A_ACT, 32'h0);
        rd_chk("R10 gap window reads zero", A_GAP, 32'h0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_prio();
        t_edge();
        t_select();
        t_tie();
        t_ack();
        t_eos();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule